// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block is the register storage for an 8-bit accumulator machine. It keeps two banks of eight-bit registers: the accumulator and flag byte in one group, and the general registers B, C, D, E, H, L plus the internal address temporaries W and Z in a second group. Next to the banks sit four 16-bit pointers (program counter, stack pointer and two index pointers) that have no alternate copies. The decoder and datapath around it read and write single bytes by a 3-bit register code and register pairs by a 2-bit pair code.

Two select flip-flops, one per group, choose which bank is visible. Toggling a select swaps the whole group in one cycle with no data moved. A third command exchanges the DE and HL pairs inside the visible bank. The W/Z temporary is filled one byte at a time, which suits a 16-bit address arriving as two byte transfers.

Top module: `cpu_regfile`

## Requirements
- R1: After reset every register in both banks, the four pointers and both bank selects are zero, so every output reads zero.
- R2: The byte port uses codes 000=B, 001=C, 010=D, 011=E, 100=H, 101=L, 111=A; reads are combinational from the visible bank and a write is visible from the next cycle.
- R3: Byte code 110 denotes a memory operand: a byte write with it changes no register and a byte read with it returns 0.
- R4: Pair codes are 00=BC, 01=DE, 10=HL; code 11 selects SP when the stack-set flag is 0 and AF (A high, F low) when it is 1. The first-named register is the high byte.
- R5: The main swap command toggles the bank of BC, DE, HL and WZ together; A and F are unaffected.
- R6: The accumulator swap command toggles only the bank of A and F, independently of the main swap.
- R7: The exchange command swaps the contents of DE and HL within the visible bank; the hidden bank is untouched.
- R8: W and Z are loaded by separate byte strobes (W high, Z low) into the visible bank and read as one 16-bit value; they are not reachable by the byte or pair codes.
- R9: The pointer write port selects 00=PC, 01=SP, 10=IX, 11=IY; pointers change only through that port or a pair write to SP and are unaffected by any swap.
- R10: A write issued in the same cycle as a swap lands in the bank that was visible before the swap.
- R11: When ports collide on one register in a cycle, the later in this order wins: exchange, byte write, flag write, W/Z strobes, pair write, pointer write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd8_sel | input | 3 | Byte read code |
| rd8_data | output | 8 | Byte read data |
| wr8_en | input | 1 | Byte write enable |
| wr8_sel | input | 3 | Byte write code |
| wr8_data | input | 8 | Byte write data |
| flag_wr_en | input | 1 | Flag byte write enable |
| flag_wr_data | input | 8 | Flag byte write data |
| rdp_sel | input | 2 | Pair read code |
| rdp_stack | input | 1 | Pair read: code 11 means AF when 1, SP when 0 |
| rdp_data | output | 16 | Pair read data |
| wrp_en | input | 1 | Pair write enable |
| wrp_sel | input | 2 | Pair write code |
| wrp_stack | input | 1 | Pair write: code 11 means AF when 1, SP when 0 |
| wrp_data | input | 16 | Pair write data |
| tmp_hi_we | input | 1 | Load W from tmp_byte |
| tmp_lo_we | input | 1 | Load Z from tmp_byte |
| tmp_byte | input | 8 | Byte for W or Z |
| ptr_we | input | 1 | Pointer write enable |
| ptr_sel | input | 2 | Pointer select |
| ptr_data | input | 16 | Pointer write data |
| swap_main | input | 1 | Toggle BC/DE/HL/WZ bank |
| swap_acc | input | 1 | Toggle A/F bank |
| xchg_dehl | input | 1 | Exchange DE and HL in visible bank |
| acc_q | output | 8 | Visible A |
| flag_q | output | 8 | Visible F |
| tmp_q | output | 16 | Visible WZ |
| pc_q | output | 16 | Program counter |
| sp_q | output | 16 | Stack pointer |
| ix_q | output | 16 | Index pointer X |
| iy_q | output | 16 | Index pointer Y |

## Verification
Directed sequences place distinct values in both banks, then toggle each select alone, both together, and interleave the exchange, which separates a swap of the wrong group, a swap that copies instead of selecting, and an exchange that touches the hidden bank. Writes paired with swaps in the same cycle show whether data lands in the pre-swap bank, and stacked colliding writes show the port ordering. A long run of mixed random commands and read codes is then compared each cycle against a behavioural model, covering the 110 code, both meanings of pair code 11, and the pointer port.

// File: rtl/cpu_regfile.sv
module cpu_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  rd8_sel,
  output logic [7:0]  rd8_data,
  input  logic        wr8_en,
  input  logic [2:0]  wr8_sel,
  input  logic [7:0]  wr8_data,
  input  logic        flag_wr_en,
  input  logic [7:0]  flag_wr_data,
  input  logic [1:0]  rdp_sel,
  input  logic        rdp_stack,
  output logic [15:0] rdp_data,
  input  logic        wrp_en,
  input  logic [1:0]  wrp_sel,
  input  logic        wrp_stack,
  input  logic [15:0] wrp_data,
  input  logic        tmp_hi_we,
  input  logic        tmp_lo_we,
  input  logic [7:0]  tmp_byte,
  input  logic        ptr_we,
  input  logic [1:0]  ptr_sel,
  input  logic [15:0] ptr_data,
  input  logic        swap_main,
  input  logic        swap_acc,
  input  logic        xchg_dehl,
  output logic [7:0]  acc_q,
  output logic [7:0]  flag_q,
  output logic [15:0] tmp_q,
  output logic [15:0] pc_q,
  output logic [15:0] sp_q,
  output logic [15:0] ix_q,
  output logic [15:0] iy_q
);
  // gp slots: 0 B, 1 C, 2 D, 3 E, 4 H, 5 L, 6 W, 7 Z
  logic [7:0]  gp  [2][8];
  logic [7:0]  acc [2];
  logic [7:0]  flg [2];
  logic        gsel, asel;
  logic [15:0] pc_r, sp_r, ix_r, iy_r;
  logic [15:0] de_act, hl_act;

  assign acc_q  = acc[asel];
  assign flag_q = flg[asel];
  assign tmp_q  = {gp[gsel][6], gp[gsel][7]};
  assign de_act = {gp[gsel][2], gp[gsel][3]};
  assign hl_act = {gp[gsel][4], gp[gsel][5]};
  assign pc_q = pc_r;
  assign sp_q = sp_r;
  assign ix_q = ix_r;
  assign iy_q = iy_r;

  always_comb begin
    case (rd8_sel)
      3'b111:  rd8_data = acc[asel];
      3'b110:  rd8_data = 8'h00;
      default: rd8_data = gp[gsel][rd8_sel];
    endcase
  end

  always_comb begin
    if (rdp_sel == 2'b11)
      rdp_data = rdp_stack ? {acc[asel], flg[asel]} : sp_r;
    else
      rdp_data = {gp[gsel][{rdp_sel, 1'b0}], gp[gsel][{rdp_sel, 1'b1}]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++) begin
        for (int r = 0; r < 8; r++) gp[b][r] <= '0;
        acc[b] <= '0;
        flg[b] <= '0;
      end
      gsel <= 1'b0;
      asel <= 1'b0;
      pc_r <= '0;
      sp_r <= '0;
      ix_r <= '0;
      iy_r <= '0;
    end else begin
      if (xchg_dehl) begin
        gp[gsel][2] <= gp[gsel][4];
        gp[gsel][3] <= gp[gsel][5];
        gp[gsel][4] <= gp[gsel][2];
        gp[gsel][5] <= gp[gsel][3];
      end
      if (wr8_en) begin
        if (wr8_sel == 3'b111) acc[asel] <= wr8_data;
        else if (wr8_sel != 3'b110) gp[gsel][wr8_sel] <= wr8_data;
      end
      if (flag_wr_en) flg[asel] <= flag_wr_data;
      if (tmp_hi_we) gp[gsel][6] <= tmp_byte;
      if (tmp_lo_we) gp[gsel][7] <= tmp_byte;
      if (wrp_en) begin
        if (wrp_sel != 2'b11) begin
          gp[gsel][{wrp_sel, 1'b0}] <= wrp_data[15:8];
          gp[gsel][{wrp_sel, 1'b1}] <= wrp_data[7:0];
        end else if (wrp_stack) begin
          acc[asel] <= wrp_data[15:8];
          flg[asel] <= wrp_data[7:0];
        end else begin
          sp_r <= wrp_data;
        end
      end
      if (ptr_we) begin
        case (ptr_sel)
          2'b00: pc_r <= ptr_data;
          2'b01: sp_r <= ptr_data;
          2'b10: ix_r <= ptr_data;
          2'b11: iy_r <= ptr_data;
        endcase
      end
      if (swap_main) gsel <= ~gsel;
      if (swap_acc)  asel <= ~asel;
    end
  end
endmodule

// File: rtl/cpu_regfile_chk.sv
module cpu_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  rd8_sel,
  input logic [7:0]  rd8_data,
  input logic        wr8_en,
  input logic [2:0]  wr8_sel,
  input logic        flag_wr_en,
  input logic        wrp_en,
  input logic [1:0]  wrp_sel,
  input logic        wrp_stack,
  input logic        tmp_hi_we,
  input logic        tmp_lo_we,
  input logic        ptr_we,
  input logic        swap_main,
  input logic        swap_acc,
  input logic        xchg_dehl,
  input logic [7:0]  acc_q,
  input logic [7:0]  flag_q,
  input logic [15:0] tmp_q,
  input logic [15:0] pc_q,
  input logic [15:0] sp_q,
  input logic [15:0] ix_q,
  input logic [15:0] iy_q,
  input logic        gsel,
  input logic [15:0] de_act,
  input logic [15:0] hl_act
);
  logic gp_quiet;
  assign gp_quiet = !wr8_en && !wrp_en && !tmp_hi_we && !tmp_lo_we;

  assert_rd_memcode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd8_sel == 3'b110) |-> (rd8_data == 8'h00));

  assert_wr_memcode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr8_en && wr8_sel == 3'b110 && !wrp_en && !flag_wr_en && !tmp_hi_we && !tmp_lo_we
     && !xchg_dehl && !swap_main && !swap_acc)
    |=> ($stable(de_act) && $stable(hl_act) && $stable(acc_q) && $stable(tmp_q)));

  assert_main_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    swap_main |=> (gsel != $past(gsel)));

  assert_main_keeps_acc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_main && !swap_acc && !wr8_en && !flag_wr_en && !wrp_en)
    |=> ($stable(acc_q) && $stable(flag_q)));

  assert_acc_swap_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (swap_acc && !swap_main && gp_quiet && !xchg_dehl)
    |=> ($stable(de_act) && $stable(hl_act) && $stable(tmp_q)));

  assert_xchg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (xchg_dehl && !swap_main && !wr8_en && !wrp_en)
    |=> (de_act == $past(hl_act) && hl_act == $past(de_act)));

  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_we && !(wrp_en && wrp_sel == 2'b11 && !wrp_stack))
    |=> ($stable(pc_q) && $stable(sp_q) && $stable(ix_q) && $stable(iy_q)));
endmodule

bind cpu_regfile cpu_regfile_chk chk (
  .clk(clk), .rst_n(rst_n), .rd8_sel(rd8_sel), .rd8_data(rd8_data),
  .wr8_en(wr8_en), .wr8_sel(wr8_sel), .flag_wr_en(flag_wr_en),
  .wrp_en(wrp_en), .wrp_sel(wrp_sel), .wrp_stack(wrp_stack),
  .tmp_hi_we(tmp_hi_we), .tmp_lo_we(tmp_lo_we), .ptr_we(ptr_we),
  .swap_main(swap_main), .swap_acc(swap_acc), .xchg_dehl(xchg_dehl),
  .acc_q(acc_q), .flag_q(flag_q), .tmp_q(tmp_q), .pc_q(pc_q), .sp_q(sp_q),
  .ix_q(ix_q), .iy_q(iy_q), .gsel(gsel), .de_act(de_act), .hl_act(hl_act)
);

// File: tb/cpu_regfile_test.sv
module cpu_regfile_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]  rd8_sel, wr8_sel;
  logic [7:0]  rd8_data, wr8_data, flag_wr_data, tmp_byte, acc_q, flag_q;
  logic        wr8_en, flag_wr_en, rdp_stack, wrp_en, wrp_stack;
  logic [1:0]  rdp_sel, wrp_sel, ptr_sel;
  logic [15:0] rdp_data, wrp_data, ptr_data, tmp_q, pc_q, sp_q, ix_q, iy_q;
  logic        tmp_hi_we, tmp_lo_we, ptr_we, swap_main, swap_acc, xchg_dehl;

  cpu_regfile uut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R1";

  // behavioural reference: slots B C D E H L W Z
  logic [7:0]  mg [2][8];
  logic [7:0]  ma [2];
  logic [7:0]  mf [2];
  int          gb = 0, ab = 0;
  logic [15:0] mpc = 0, msp = 0, mix = 0, miy = 0;

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp8(int code);
    if (code == 7) return ma[ab];
    if (code == 6) return 8'h00;
    return mg[gb][code];
  endfunction

  function automatic logic [15:0] expp(int code, bit stk);
    if (code == 3) return stk ? {ma[ab], mf[ab]} : msp;
    return {mg[gb][2*code], mg[gb][2*code+1]};
  endfunction

  task automatic compare();
    chk({phase, " rd8"}, {8'h00, rd8_data}, {8'h00, exp8(int'(rd8_sel))});
    chk({phase, " pair"}, rdp_data, expp(int'(rdp_sel), rdp_stack));
    chk({phase, " acc"}, {8'h00, acc_q}, {8'h00, ma[ab]});
    chk({phase, " flag"}, {8'h00, flag_q}, {8'h00, mf[ab]});
    chk({phase, " wz"}, tmp_q, {mg[gb][6], mg[gb][7]});
    chk({phase, " ptr"}, {pc_q ^ ix_q, sp_q ^ iy_q}, {mpc ^ mix, msp ^ miy});
    chk({phase, " ix"}, ix_q, mix);
  endtask

  task automatic model_update();
    int g = gb;
    int a = ab;
    logic [7:0] d, e;
    if (xchg_dehl) begin
      d = mg[g][2]; e = mg[g][3];
      mg[g][2] = mg[g][4]; mg[g][3] = mg[g][5];
      mg[g][4] = d; mg[g][5] = e;
    end
    if (wr8_en) begin
      if (wr8_sel == 7) ma[a] = wr8_data;
      else if (wr8_sel != 6) mg[g][wr8_sel] = wr8_data;
    end
    if (flag_wr_en) mf[a] = flag_wr_data;
    if (tmp_hi_we) mg[g][6] = tmp_byte;
    if (tmp_lo_we) mg[g][7] = tmp_byte;
    if (wrp_en) begin
      if (wrp_sel == 3) begin
        if (wrp_stack) begin ma[a] = wrp_data[15:8]; mf[a] = wrp_data[7:0]; end
        else msp = wrp_data;
      end else begin
        mg[g][2*wrp_sel] = wrp_data[15:8];
        mg[g][2*wrp_sel+1] = wrp_data[7:0];
      end
    end
    if (ptr_we) begin
      if (ptr_sel == 0) mpc = ptr_data;
      else if (ptr_sel == 1) msp = ptr_data;
      else if (ptr_sel == 2) mix = ptr_data;
      else miy = ptr_data;
    end
    if (swap_main) gb ^= 1;
    if (swap_acc)  ab ^= 1;
  endtask

  task automatic idle();
    wr8_en = 0; flag_wr_en = 0; wrp_en = 0; tmp_hi_we = 0; tmp_lo_we = 0;
    ptr_we = 0; swap_main = 0; swap_acc = 0; xchg_dehl = 0;
  endtask

  // inputs are set at a negedge; compare, clock, update model, return at next negedge
  task automatic cyc();
    #1 compare();
    @(posedge clk);
    #1 model_update();
    @(negedge clk);
  endtask

  task automatic w8(int code, logic [7:0] v);
    idle(); wr8_en = 1; wr8_sel = code[2:0]; wr8_data = v; cyc(); idle();
  endtask

  task automatic wp(int code, bit stk, logic [15:0] v);
    idle(); wrp_en = 1; wrp_sel = code[1:0]; wrp_stack = stk; wrp_data = v; cyc(); idle();
  endtask

  task automatic read_all();
    idle();
    for (int i = 0; i < 8; i++) begin
      rd8_sel = i[2:0]; rdp_sel = i[1:0]; rdp_stack = i[2]; cyc();
    end
  endtask

  task automatic peek_pair(int code, bit stk);
    rdp_sel = code[1:0]; rdp_stack = stk; #1;
  endtask

  initial begin
    for (int b = 0; b < 2; b++) begin
      for (int r = 0; r < 8; r++) mg[b][r] = 0;
      ma[b] = 0; mf[b] = 0;
    end
    idle();
    rd8_sel = 0; wr8_sel = 0; wr8_data = 0; flag_wr_data = 0; rdp_sel = 0; rdp_stack = 0;
    wrp_sel = 0; wrp_stack = 0; wrp_data = 0; tmp_byte = 0; ptr_sel = 0; ptr_data = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    phase = "R1";
    #1 chk("R1 acc", {8'h00, acc_q}, 16'h0);
    chk("R1 wz", tmp_q, 16'h0);
    chk("R1 pc", pc_q, 16'h0);
    read_all();

    phase = "R2";
    for (int i = 0; i < 8; i++) w8(i, 8'h10 + 8'(i));
    rd8_sel = 3'b111; #1 chk("R2 A", {8'h00, rd8_data}, 16'h0017);
    rd8_sel = 3'b011; #1 chk("R2 E", {8'h00, rd8_data}, 16'h0013);
    read_all();

    phase = "R3";
    w8(6, 8'hFF);
    rd8_sel = 3'b110; #1 chk("R3 read 110", {8'h00, rd8_data}, 16'h0000);
    read_all();

    phase = "R4";
    idle(); flag_wr_en = 1; flag_wr_data = 8'hC5; cyc(); idle();
    peek_pair(0, 0); chk("R4 BC", rdp_data, 16'h1011);
    peek_pair(3, 1); chk("R4 AF", rdp_data, 16'h17C5);
    wp(3, 0, 16'hBEEF);
    peek_pair(3, 0); chk("R4 SP", rdp_data, 16'hBEEF);
    wp(2, 0, 16'h1111);
    read_all();

    phase = "R8";
    idle(); tmp_hi_we = 1; tmp_byte = 8'hAB; cyc();
    idle(); tmp_lo_we = 1; tmp_byte = 8'hCD; cyc(); idle();
    #1 chk("R8 wz", tmp_q, 16'hABCD);

    phase = "R5";
    idle(); swap_main = 1; cyc(); idle();
    peek_pair(2, 0); chk("R5 alt HL", rdp_data, 16'h0000);
    chk("R5 wz alt", tmp_q, 16'h0000);
    chk("R5 A kept", {8'h00, acc_q}, 16'h0017);
    wp(2, 0, 16'h5555);
    idle(); swap_main = 1; cyc(); idle();
    peek_pair(2, 0); chk("R5 main HL back", rdp_data, 16'h1111);
    chk("R5 wz back", tmp_q, 16'hABCD);

    phase = "R6";
    idle(); swap_acc = 1; cyc(); idle();
    #1 chk("R6 alt A", {8'h00, acc_q}, 16'h0000);
    peek_pair(2, 0); chk("R6 HL kept", rdp_data, 16'h1111);
    idle(); swap_acc = 1; cyc(); idle();
    #1 chk("R6 A back", {8'h00, acc_q}, 16'h0017);

    phase = "R7";
    wp(1, 0, 16'h2222);
    idle(); xchg_dehl = 1; cyc(); idle();
    peek_pair(1, 0); chk("R7 DE", rdp_data, 16'h1111);
    peek_pair(2, 0); chk("R7 HL", rdp_data, 16'h2222);
    idle(); swap_main = 1; cyc(); idle();
    peek_pair(2, 0); chk("R7 alt HL untouched", rdp_data, 16'h5555);
    idle(); swap_main = 1; cyc(); idle();

    phase = "R9";
    idle(); ptr_we = 1; ptr_sel = 0; ptr_data = 16'h1234; cyc();
    ptr_sel = 2; ptr_data = 16'h4444; cyc();
    ptr_sel = 3; ptr_data = 16'h8888; cyc(); idle();
    swap_main = 1; swap_acc = 1; cyc(); idle();
    #1 chk("R9 pc", pc_q, 16'h1234);
    chk("R9 iy", iy_q, 16'h8888);

    phase = "R10";
    idle(); wr8_en = 1; wr8_sel = 3'b111; wr8_data = 8'h77; swap_acc = 1; cyc(); idle();
    #1 chk("R10 swapped away", {8'h00, acc_q}, 16'h0017);
    idle(); swap_acc = 1; cyc(); idle();
    #1 chk("R10 pre-swap bank", {8'h00, acc_q}, 16'h0077);

    phase = "R11";
    idle(); wr8_en = 1; wr8_sel = 3'b000; wr8_data = 8'h99;
    wrp_en = 1; wrp_sel = 2'b00; wrp_stack = 0; wrp_data = 16'h4321; cyc(); idle();
    peek_pair(0, 0); chk("R11 pair over byte", rdp_data, 16'h4321);
    idle(); wrp_en = 1; wrp_sel = 2'b11; wrp_stack = 0; wrp_data = 16'h0101;
    ptr_we = 1; ptr_sel = 2'b01; ptr_data = 16'h0202; cyc(); idle();
    #1 chk("R11 ptr over pair", sp_q, 16'h0202);
    idle(); xchg_dehl = 1; wr8_en = 1; wr8_sel = 3'b100; wr8_data = 8'h3C; cyc(); idle();
    read_all();

    phase = "R11 mixed";
    for (int n = 0; n < 3000; n++) begin
      rd8_sel = 3'($urandom); rdp_sel = 2'($urandom); rdp_stack = 1'($urandom);
      wr8_en = ($urandom_range(0, 2) == 0); wr8_sel = 3'($urandom); wr8_data = 8'($urandom);
      flag_wr_en = ($urandom_range(0, 4) == 0); flag_wr_data = 8'($urandom);
      wrp_en = ($urandom_range(0, 3) == 0); wrp_sel = 2'($urandom);
      wrp_stack = 1'($urandom); wrp_data = 16'($urandom);
      tmp_hi_we = ($urandom_range(0, 5) == 0); tmp_lo_we = ($urandom_range(0, 5) == 0);
      tmp_byte = 8'($urandom);
      ptr_we = ($urandom_range(0, 5) == 0); ptr_sel = 2'($urandom); ptr_data = 16'($urandom);
      swap_main = ($urandom_range(0, 3) == 0); swap_acc = ($urandom_range(0, 3) == 0);
      xchg_dehl = ($urandom_range(0, 4) == 0);
      cyc();
    end
    idle();
    read_all();

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule